// File: doc/BRIEF.md
# Per-Tile Frame-Coherent Visibility Predictor

This block sits beside the binning stage of a tile-based renderer. Each time a primitive is binned into a screen tile, the block decides whether that primitive is likely to end up fully hidden inside the tile. It makes the call from what the previous frame left behind: the farthest depth that stayed visible in each tile once the tile was finished. A primitive whose nearest point lies behind that depth is flagged as predicted occluded. Downstream logic uses the flag in two ways. It queues the flagged primitive behind the visible ones of the same tile, and it leaves the primitive out of the tile's input signature.

After a tile finishes rendering, the renderer reports the largest per-pixel depth in the tile through a separate update port. These updates are held back and switch in at the frame boundary, so every prediction in a frame sees one consistent table. Primitives drawn with depth testing off are counted per tile. A tile that had any of them in the previous frame is treated as unpredictable and never flags anything. A wrong guess costs only efficiency: flagged primitives still pass through the normal depth test.

Top module: `vis_predictor`

## Requirements
- R1: After reset every tile's stored depth is all ones (24-bit 0xFFFFFF by default), so no primitive is predicted occluded before the first frame boundary. After reset pred_valid, pred_occluded and pred_sig_en are 0.
- R2: A primitive is predicted occluded only when its nearest depth is strictly greater than the tile's stored depth, where larger means farther. Equal or nearer depths are predicted visible.
- R3: A primitive with bin_ztest_en = 0 is always predicted visible.
- R4: When the tile received one or more depth-test-disabled primitives during the previous frame, every primitive in that tile is predicted visible.
- R5: A stored-depth update is used by predictions only after the next frame_end pulse. An update presented in the same cycle as frame_end counts toward that boundary.
- R6: A tile that receives no update during a frame keeps its previous stored depth across the boundary.
- R7: While pred_valid = 1, pred_occluded = 1 marks the late issue group and pred_sig_en = 1 marks signature inclusion, and the two are always complementary. While pred_valid = 0, both are 0.
- R8: pred_valid rises exactly one clock after each binned primitive, and pred_tile echoes that primitive's tile index.
- R9: The depth-test-disabled count of frame N affects only frame N+1. A tile that has no such primitives in frame N+1 predicts normally again in frame N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle pulse at the frame boundary |
| bin_valid | input | 1 | A tile/primitive pair is presented |
| bin_tile | input | TILE_W (4) | Tile index of the pair |
| bin_zmin | input | DEPTH_W (24) | Nearest depth of the primitive |
| bin_ztest_en | input | 1 | Primitive uses the depth test |
| fvp_wr_valid | input | 1 | Finished-tile depth update strobe |
| fvp_wr_tile | input | TILE_W (4) | Tile being updated |
| fvp_wr_depth | input | DEPTH_W (24) | Largest per-pixel depth of the finished tile |
| pred_valid | output | 1 | Prediction valid |
| pred_tile | output | TILE_W (4) | Tile of the prediction |
| pred_occluded | output | 1 | Predicted hidden; issue in the late group |
| pred_sig_en | output | 1 | Include the primitive in the tile signature |

## Verification
The bench targets the comparison boundary, where a depth equal to the stored value must stay visible; a design using >= there would flag primitives that touch the farthest visible surface. It checks that an update written mid-frame stays invisible until the boundary, and that an update arriving together with frame_end is not lost. A design without this staging would change predictions halfway through a frame, and a design that drops the coincident write would keep the old depth. It also checks the layer rule across three frames: a tile with unordered drawing must be suppressed for exactly one frame, so a counter that never clears, or one that acts within the same frame, shows up as a wrong flag.

// File: rtl/vp_pkg.sv
package vp_pkg;

   // Issue group of a binned primitive within its tile
   typedef enum logic {
      GRP_EARLY = 1'b0,
      GRP_LATE  = 1'b1
   } issue_grp_e;

   localparam int unsigned VP_DEPTH_W_DEF = 24;
   localparam int unsigned VP_TILES_DEF   = 16;
   localparam int unsigned VP_LAYER_W_DEF = 4;

endpackage

// File: rtl/vp_fvp_table.sv
// Farthest-visible depth per tile: pending copy written by finished tiles,
// active copy read by predictions, swapped in on each frame boundary.
module vp_fvp_table #(
   parameter int unsigned NUM_TILES = 16,
   parameter int unsigned DEPTH_W   = 24,
   parameter int unsigned TILE_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic [TILE_W-1:0]  wr_tile,
   input  logic [DEPTH_W-1:0] wr_depth,
   input  logic               commit,
   input  logic [TILE_W-1:0]  rd_tile,
   output logic [DEPTH_W-1:0] rd_depth
);

   localparam logic [DEPTH_W-1:0] FAR_Z = {DEPTH_W{1'b1}};

   logic [DEPTH_W-1:0] pend_q [NUM_TILES];
   logic [DEPTH_W-1:0] act_q  [NUM_TILES];

   for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
      logic hit;
      assign hit = wr_valid && (wr_tile == TILE_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[t] <= FAR_Z;
            act_q[t]  <= FAR_Z;
         end else begin
            if (hit) pend_q[t] <= wr_depth;
            if (commit) act_q[t] <= hit ? wr_depth : pend_q[t];
         end
      end
   end

   always_comb begin
      rd_depth = FAR_Z;
      for (int i = 0; i < NUM_TILES; i++) begin
         if (rd_tile == TILE_W'(i)) rd_depth = act_q[i];
      end
   end

endmodule

// File: rtl/vp_layer_track.sv
// Per-tile count of depth-test-disabled primitives; the count of the
// finished frame is kept for the next one.
module vp_layer_track #(
   parameter int unsigned NUM_TILES = 16,
   parameter int unsigned LAYER_W   = 4,
   parameter int unsigned TILE_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_valid,
   input  logic [TILE_W-1:0] inc_tile,
   input  logic              commit,
   input  logic [TILE_W-1:0] rd_tile,
   output logic              rd_layered
);

   localparam logic [LAYER_W-1:0] CNT_MAX = {LAYER_W{1'b1}};

   logic [LAYER_W-1:0] cur_q  [NUM_TILES];
   logic [LAYER_W-1:0] prev_q [NUM_TILES];

   for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
      logic               hit;
      logic [LAYER_W-1:0] cur_next;
      assign hit      = inc_valid && (inc_tile == TILE_W'(t));
      assign cur_next = (hit && cur_q[t] != CNT_MAX) ? cur_q[t] + 1'b1 : cur_q[t];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur_q[t]  <= '0;
            prev_q[t] <= '0;
         end else if (commit) begin
            prev_q[t] <= cur_next;
            cur_q[t]  <= '0;
         end else begin
            cur_q[t]  <= cur_next;
         end
      end
   end

   always_comb begin
      rd_layered = 1'b0;
      for (int i = 0; i < NUM_TILES; i++) begin
         if (rd_tile == TILE_W'(i)) rd_layered = (prev_q[i] != '0);
      end
   end

endmodule

// File: rtl/vp_decide.sv
// Turns the looked-up tile state into an issue group and signature enable.
module vp_decide #(
   parameter int unsigned DEPTH_W  = 24,
   parameter int unsigned TILE_W   = 4,
   parameter bit          PRED_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [TILE_W-1:0]  in_tile,
   input  logic [DEPTH_W-1:0] in_zmin,
   input  logic               in_ztest,
   input  logic [DEPTH_W-1:0] tile_fvp,
   input  logic               tile_layered,
   output logic               out_valid,
   output logic [TILE_W-1:0]  out_tile,
   output logic               out_occluded,
   output logic               out_sig_en
);
   import vp_pkg::*;

   issue_grp_e grp_d, grp_s;
   logic              valid_s;
   logic [TILE_W-1:0] tile_s;

   always_comb begin
      grp_d = GRP_EARLY;
      if (in_valid && in_ztest && !tile_layered && (in_zmin > tile_fvp))
         grp_d = GRP_LATE;
   end

   if (PRED_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_s <= 1'b0;
            tile_s  <= '0;
            grp_s   <= GRP_EARLY;
         end else begin
            valid_s <= in_valid;
            tile_s  <= in_tile;
            grp_s   <= grp_d;
         end
      end
   end else begin : g_comb
      assign valid_s = in_valid;
      assign tile_s  = in_tile;
      assign grp_s   = grp_d;
   end

   assign out_valid    = valid_s;
   assign out_tile     = tile_s;
   assign out_occluded = valid_s && (grp_s == GRP_LATE);
   assign out_sig_en   = valid_s && (grp_s == GRP_EARLY);

endmodule

// File: rtl/vis_predictor.sv
module vis_predictor #(
   parameter int unsigned NUM_TILES = vp_pkg::VP_TILES_DEF,
   parameter int unsigned DEPTH_W   = vp_pkg::VP_DEPTH_W_DEF,
   parameter int unsigned LAYER_W   = vp_pkg::VP_LAYER_W_DEF,
   parameter bit          PRED_REG  = 1'b1,
   localparam int unsigned TILE_W   = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_end,
   input  logic               bin_valid,
   input  logic [TILE_W-1:0]  bin_tile,
   input  logic [DEPTH_W-1:0] bin_zmin,
   input  logic               bin_ztest_en,
   input  logic               fvp_wr_valid,
   input  logic [TILE_W-1:0]  fvp_wr_tile,
   input  logic [DEPTH_W-1:0] fvp_wr_depth,
   output logic               pred_valid,
   output logic [TILE_W-1:0]  pred_tile,
   output logic               pred_occluded,
   output logic               pred_sig_en
);

   if (NUM_TILES < 2) begin : g_bad_tiles
      $error("vis_predictor: NUM_TILES must be at least 2");
   end
   if (DEPTH_W < 1 || DEPTH_W > 32) begin : g_bad_depth
      $error("vis_predictor: DEPTH_W must be 1..32");
   end
   if (LAYER_W < 1) begin : g_bad_layer
      $error("vis_predictor: LAYER_W must be at least 1");
   end

   logic [DEPTH_W-1:0] fvp_rd;
   logic               layered;

   vp_fvp_table #(
      .NUM_TILES(NUM_TILES), .DEPTH_W(DEPTH_W), .TILE_W(TILE_W)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (fvp_wr_valid),
      .wr_tile  (fvp_wr_tile),
      .wr_depth (fvp_wr_depth),
      .commit   (frame_end),
      .rd_tile  (bin_tile),
      .rd_depth (fvp_rd)
   );

   vp_layer_track #(
      .NUM_TILES(NUM_TILES), .LAYER_W(LAYER_W), .TILE_W(TILE_W)
   ) i_layers (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_valid  (bin_valid && !bin_ztest_en),
      .inc_tile   (bin_tile),
      .commit     (frame_end),
      .rd_tile    (bin_tile),
      .rd_layered (layered)
   );

   vp_decide #(
      .DEPTH_W(DEPTH_W), .TILE_W(TILE_W), .PRED_REG(PRED_REG)
   ) i_decide (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (bin_valid),
      .in_tile      (bin_tile),
      .in_zmin      (bin_zmin),
      .in_ztest     (bin_ztest_en),
      .tile_fvp     (fvp_rd),
      .tile_layered (layered),
      .out_valid    (pred_valid),
      .out_tile     (pred_tile),
      .out_occluded (pred_occluded),
      .out_sig_en   (pred_sig_en)
   );

endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
   parameter int unsigned DEPTH_W  = 24,
   parameter int unsigned TILE_W   = 4,
   parameter bit          PRED_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_end,
   input logic               bin_valid,
   input logic [TILE_W-1:0]  bin_tile,
   input logic [DEPTH_W-1:0] bin_zmin,
   input logic               bin_ztest_en,
   input logic               pred_valid,
   input logic [TILE_W-1:0]  pred_tile,
   input logic               pred_occluded,
   input logic               pred_sig_en
);

   logic boundary_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)         boundary_seen <= 1'b0;
      else if (frame_end) boundary_seen <= 1'b1;
   end

   AST_GROUPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> (pred_sig_en != pred_occluded)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_valid |-> (!pred_occluded && !pred_sig_en)); // R7

   if (PRED_REG) begin : g_lat
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         bin_valid |=> pred_valid); // R8
      AST_TILE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
         bin_valid |=> (pred_tile == $past(bin_tile))); // R8
      AST_NOZTEST_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
         (bin_valid && !bin_ztest_en) |=> !pred_occluded); // R3
      AST_NEAREST_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
         (bin_valid && bin_zmin == '0) |=> !pred_occluded); // R2
      AST_FIRST_FRAME_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
         (bin_valid && !boundary_seen) |=> !pred_occluded); // R1
   end

endmodule

bind vis_predictor vp_checker #(
   .DEPTH_W(DEPTH_W), .TILE_W(TILE_W), .PRED_REG(PRED_REG)
) i_vp_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_end     (frame_end),
   .bin_valid     (bin_valid),
   .bin_tile      (bin_tile),
   .bin_zmin      (bin_zmin),
   .bin_ztest_en  (bin_ztest_en),
   .pred_valid    (pred_valid),
   .pred_tile     (pred_tile),
   .pred_occluded (pred_occluded),
   .pred_sig_en   (pred_sig_en)
);

// File: tb/test_vis_predictor.sv
module test_vis_predictor;

   localparam int CLK_P = 10;
   localparam int NV    = 17;

   // step ops
   localparam logic [1:0] OP_BIN  = 2'd0;
   localparam logic [1:0] OP_WR   = 2'd1;
   localparam logic [1:0] OP_FEND = 2'd2;
   localparam logic [1:0] OP_WRFE = 2'd3;

   // {req[3:0], op[1:0], tile[3:0], depth[23:0], ztest, exp_occ} = 36 bits
   function automatic logic [35:0] mk(input logic [3:0] rq, input logic [1:0] op,
                                      input logic [3:0] t, input logic [23:0] z,
                                      input logic zt, input logic occ);
      return {rq, op, t, z, zt, occ};
   endfunction

   localparam logic [35:0] VEC [NV] = '{
      mk(4'd1, OP_BIN,  4'd3, 24'd100,     1'b1, 1'b0), // R1 first frame
      mk(4'd1, OP_BIN,  4'd3, 24'hFFFFFF,  1'b1, 1'b0), // R1 farthest equals reset value
      mk(4'd5, OP_WR,   4'd3, 24'd500,     1'b1, 1'b0), // R5 pending update
      mk(4'd5, OP_BIN,  4'd3, 24'd600,     1'b1, 1'b0), // R5 not yet in effect
      mk(4'd5, OP_WRFE, 4'd5, 24'd700,     1'b1, 1'b0), // R5 update with boundary
      mk(4'd2, OP_BIN,  4'd3, 24'd600,     1'b1, 1'b1), // R2 farther -> occluded
      mk(4'd2, OP_BIN,  4'd3, 24'd500,     1'b1, 1'b0), // R2 equal -> visible
      mk(4'd2, OP_BIN,  4'd3, 24'd499,     1'b1, 1'b0), // R2 nearer -> visible
      mk(4'd5, OP_BIN,  4'd5, 24'd701,     1'b1, 1'b1), // R5 coincident write kept
      mk(4'd3, OP_BIN,  4'd3, 24'd600,     1'b0, 1'b0), // R3 no depth test
      mk(4'd6, OP_BIN,  4'd7, 24'hFFFFFF,  1'b1, 1'b0), // R6 untouched tile
      mk(4'd9, OP_FEND, 4'd0, 24'd0,       1'b0, 1'b0), // R9 boundary
      mk(4'd4, OP_BIN,  4'd3, 24'd600,     1'b1, 1'b0), // R4 layered tile
      mk(4'd6, OP_BIN,  4'd5, 24'd701,     1'b1, 1'b1), // R6 value retained
      mk(4'd9, OP_FEND, 4'd0, 24'd0,       1'b0, 1'b0), // R9 boundary
      mk(4'd9, OP_BIN,  4'd3, 24'd600,     1'b1, 1'b1), // R9 layer effect gone
      mk(4'd6, OP_BIN,  4'd3, 24'd500,     1'b1, 1'b0)  // R6 equal stays visible
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_end, bin_valid, bin_ztest_en, fvp_wr_valid;
   logic [3:0]  bin_tile, fvp_wr_tile;
   logic [23:0] bin_zmin, fvp_wr_depth;
   logic        pred_valid, pred_occluded, pred_sig_en;
   logic [3:0]  pred_tile;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   vis_predictor i_vis_predictor (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
      .bin_valid(bin_valid), .bin_tile(bin_tile), .bin_zmin(bin_zmin),
      .bin_ztest_en(bin_ztest_en), .fvp_wr_valid(fvp_wr_valid),
      .fvp_wr_tile(fvp_wr_tile), .fvp_wr_depth(fvp_wr_depth),
      .pred_valid(pred_valid), .pred_tile(pred_tile),
      .pred_occluded(pred_occluded), .pred_sig_en(pred_sig_en)
   );

   task automatic check(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      frame_end = 1'b0; bin_valid = 1'b0; bin_ztest_en = 1'b0; fvp_wr_valid = 1'b0;
      bin_tile = '0; fvp_wr_tile = '0; bin_zmin = '0; fvp_wr_depth = '0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive on a falling edge, sample on the next falling edge
   task automatic bin(input logic [3:0] t, input logic [23:0] z, input logic zt);
      idle_inputs();
      bin_valid = 1'b1; bin_tile = t; bin_zmin = z; bin_ztest_en = zt;
      @(negedge clk);
   endtask

   task automatic check_pred(input string rq, input logic [3:0] t, input logic occ);
      check(rq, "pred_valid", int'(pred_valid), 1);
      check(rq, "pred_tile", int'(pred_tile), int'(t));
      check(rq, "pred_occluded", int'(pred_occluded), int'(occ));
      check(rq, "pred_sig_en", int'(pred_sig_en), int'(!occ));
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R1: outputs quiet after reset
      check("R1", "pred_valid after reset", int'(pred_valid), 0);
      check("R1", "pred_occluded after reset", int'(pred_occluded), 0);
      check("R7", "pred_sig_en idle", int'(pred_sig_en), 0);

      for (int i = 0; i < NV; i++) begin
         logic [3:0]  rq   = VEC[i][35:32];
         logic [1:0]  op   = VEC[i][31:30];
         logic [3:0]  t    = VEC[i][29:26];
         logic [23:0] z    = VEC[i][25:2];
         logic        zt   = VEC[i][1];
         logic        occ  = VEC[i][0];
         string       tag  = $sformatf("R%0d", rq);
         idle_inputs();
         case (op)
            OP_BIN: begin
               bin(t, z, zt);
               check_pred(tag, t, occ);
            end
            OP_WR: begin
               fvp_wr_valid = 1'b1; fvp_wr_tile = t; fvp_wr_depth = z;
               @(negedge clk);
               check(tag, "pred_valid idle", int'(pred_valid), 0);
            end
            OP_FEND: begin
               frame_end = 1'b1;
               @(negedge clk);
               check(tag, "pred_valid idle", int'(pred_valid), 0);
            end
            default: begin
               frame_end = 1'b1;
               fvp_wr_valid = 1'b1; fvp_wr_tile = t; fvp_wr_depth = z;
               @(negedge clk);
               check(tag, "pred_sig_en idle", int'(pred_sig_en), 0);
            end
         endcase
      end

      // R8: a gap in binning drops pred_valid the next cycle
      idle_inputs();
      @(negedge clk);
      check("R8", "pred_valid after gap", int'(pred_valid), 0);

      // R1: reset restores the all-ones table (tile 5 held 700)
      do_reset();
      bin(4'd5, 24'd701, 1'b1);
      check_pred("R1", 4'd5, 1'b0);

      // R2: maximum depth against a written tile, and zero depth
      idle_inputs();
      fvp_wr_valid = 1'b1; fvp_wr_tile = 4'd15; fvp_wr_depth = 24'd0;
      @(negedge clk);
      idle_inputs(); frame_end = 1'b1;
      @(negedge clk);
      bin(4'd15, 24'd1, 1'b1);
      check_pred("R2", 4'd15, 1'b1);
      bin(4'd15, 24'd0, 1'b1);
      check_pred("R2", 4'd15, 1'b0);

      idle_inputs();
      @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule